// File: doc/BRIEF.md
# Modem Line Status and Control with Loopback

This block holds the modem-control and modem-status registers of a 16550-style serial port. It watches four incoming handshake lines (clear-to-send, data-set-ready, carrier-detect and ring), passes each through a two-flop synchronizer, and records in sticky delta bits any change it sees. A status read returns the current line levels together with the delta bits, and clears the deltas. A delta-pending flag tells the interrupt logic that at least one delta is set.

The control register drives four output pins: data-terminal-ready, request-to-send and two general outputs. It also holds a loopback enable. With loopback on, the control bits take the place of the external lines as the status source, and the four pins are held inactive. All pins are active-high plain levels. There is no data stream here, so every port is a plain control or status signal with no handshake. Address decoding belongs to the surrounding bus logic, which supplies single-cycle write and read strobes.

Top module: `modem_status_unit`

## Requirements
- R1: After reset, the control read value is 0x08, `out2_o` is 1 while the other three pins are 0, the status read value is 0xB0 and `delta_pend` is 0. This assumes the lines are held at cts=1, dsr=1, dcd=1 and ri=0 during reset.
- R2: Status bits 7, 6, 5 and 4 give the carrier, ring, data-set-ready and clear-to-send levels. A change on an external line shows on the status value at the third rising edge after it is applied, and not before.
- R3: Delta bits 0 (clear-to-send), 1 (data-set-ready) and 3 (carrier) are set on either edge of their line, in the same cycle that the line's status bit changes.
- R4: Delta bit 2 (ring) is set only when the ring level goes from 1 to 0. A rise from 0 to 1 leaves bit 2 and `delta_pend` clear.
- R5: A cycle with `stat_rd` high returns the status value as it was before the read, and clears bits 3:0 at the following edge. A line change recorded in that same edge still sets its delta bit.
- R6: A delta bit stays set until a status read, even if its line returns to its earlier level.
- R7: `delta_pend` is 1 exactly when any of status bits 3:0 is 1.
- R8: A control write stores bit 0 (data-terminal-ready), bit 1 (request-to-send), bit 2 (general out 1), bit 3 (general out 2) and bit 4 (loopback). Written bits 7:5 are ignored and read back as 0. The register and, outside loopback, the pins update at the edge that takes the write.
- R9: In loopback, carrier takes general out 2, ring takes general out 1, clear-to-send takes request-to-send, and data-set-ready takes data-terminal-ready. The status reflects this one edge after the control write, with deltas from the change, and the external lines have no effect.
- R10: In loopback, all four output pins are 0, whatever the control bits hold.
- R11: When loopback is turned off, the status returns, one edge after the write, to the synchronized external levels, and sets deltas for any line that differs from the looped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_in | input | 1 | External clear-to-send line (asynchronous) |
| dsr_in | input | 1 | External data-set-ready line (asynchronous) |
| dcd_in | input | 1 | External carrier-detect line (asynchronous) |
| ri_in | input | 1 | External ring line (asynchronous) |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| stat_rd | input | 1 | Status register read strobe; clears deltas |
| ctl_rdata | output | 8 | Control register read value |
| stat_rdata | output | 8 | Status register read value |
| dtr_o | output | 1 | Data-terminal-ready pin |
| rts_o | output | 1 | Request-to-send pin |
| out1_o | output | 1 | General output 1 pin |
| out2_o | output | 1 | General output 2 pin |
| delta_pend | output | 1 | Any status delta bit set |

## Verification
An external line change goes through three registers (two synchronizer stages, then the level/delta register), so its effect on the status value is due at the third edge. The bench samples after the second edge to show that the value has not changed yet, and after the third to show that it has. A control write takes effect on the register and pins at its own edge, and on the looped status one edge later. A read clears the deltas at its edge, so the pre-clear value is sampled while the strobe is high and the cleared value after that edge. All inputs are driven, and all outputs sampled, on the falling edge, so every check falls at a known edge count after its stimulus.

// File: rtl/msu_pkg.sv
package msu_pkg;
  // Line vector order matches status nibble 7:4 -> {dcd, ri, dsr, cts}
  localparam int unsigned LINE_W  = 4;
  localparam int unsigned L_CTS   = 0;
  localparam int unsigned L_DSR   = 1;
  localparam int unsigned L_RI    = 2;
  localparam int unsigned L_DCD   = 3;

  // Control register bit positions (decoded by software, so fixed)
  localparam int unsigned C_DTR   = 0;
  localparam int unsigned C_RTS   = 1;
  localparam int unsigned C_OUT1  = 2;
  localparam int unsigned C_OUT2  = 3;
  localparam int unsigned C_LOOP  = 4;
  localparam int unsigned CTL_W   = 5;

  localparam logic [LINE_W-1:0] LINE_RST   = 4'b1011; // dcd, dsr, cts high
  localparam logic [CTL_W-1:0]  CTL_RST    = 5'b01000; // general out 2 set
  localparam logic [LINE_W-1:0] FALL_ONLY  = 4'b0100;  // ring: falling edge only

  typedef logic [LINE_W-1:0] line_t;
endpackage

// File: rtl/msu_sync.sv
module msu_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/msu_ctl_reg.sv
module msu_ctl_reg
  import msu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       wdata,
  output logic [CTL_W-1:0] ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= CTL_RST;
    else if (wr) ctl_q <= wdata[CTL_W-1:0];
  end

  a_r8_write_takes: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ctl_q == $past(wdata[CTL_W-1:0]));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ctl_q));
endmodule

// File: rtl/msu_delta.sv
module msu_delta
  import msu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  line_t level_in,
  input  logic  clr,
  output line_t level_q,
  output line_t delta_q
);
  line_t hit;

  generate
    for (genvar i = 0; i < LINE_W; i++) begin : g_bit
      if (FALL_ONLY[i]) begin : g_fall
        assign hit[i] = level_q[i] & ~level_in[i];
      end else begin : g_any
        assign hit[i] = level_q[i] ^ level_in[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LINE_RST;
      delta_q <= '0;
    end else begin
      level_q <= level_in;
      delta_q <= (clr ? '0 : delta_q) | hit;
    end
  end

  // R4: ring delta rises only with a 1->0 step of the ring level
  a_r4_ring_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_q[L_RI]) |-> ($past(level_q[L_RI]) && !level_q[L_RI]));
  // R3: a change on any other line sets its delta
  a_r3_cts_change: assert property (@(posedge clk) disable iff (!rst_n)
    (level_in[L_CTS] != level_q[L_CTS]) |=> delta_q[L_CTS]);
  a_r3_dcd_change: assert property (@(posedge clk) disable iff (!rst_n)
    (level_in[L_DCD] != level_q[L_DCD]) |=> delta_q[L_DCD]);
  // R5: read with nothing changing leaves all deltas clear
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && level_in == level_q) |=> delta_q == '0);
  // R6: no read and no change keeps deltas
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && level_in == level_q) |=> $stable(delta_q));
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msu_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_in,
  input  logic       dsr_in,
  input  logic       dcd_in,
  input  logic       ri_in,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       stat_rd,
  output logic [7:0] ctl_rdata,
  output logic [7:0] stat_rdata,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       delta_pend
);
  localparam int unsigned PAD_W = 8 - CTL_W;

  line_t             raw_lines, sync_lines, loop_lines, eff_lines;
  line_t             level_q, delta_q;
  logic [CTL_W-1:0]  ctl_q;
  logic              loop_on;

  assign raw_lines = {dcd_in, ri_in, dsr_in, cts_in};

  msu_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines));

  msu_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata), .ctl_q(ctl_q));

  assign loop_on = ctl_q[C_LOOP];

  always_comb begin
    loop_lines        = '0;
    loop_lines[L_DCD] = ctl_q[C_OUT2];
    loop_lines[L_RI]  = ctl_q[C_OUT1];
    loop_lines[L_CTS] = ctl_q[C_RTS];
    loop_lines[L_DSR] = ctl_q[C_DTR];
  end

  assign eff_lines = loop_on ? loop_lines : sync_lines;

  msu_delta u_delta (
    .clk(clk), .rst_n(rst_n), .level_in(eff_lines), .clr(stat_rd),
    .level_q(level_q), .delta_q(delta_q));

  assign stat_rdata = {level_q, delta_q};
  assign ctl_rdata  = {{PAD_W{1'b0}}, ctl_q};
  assign delta_pend = |delta_q;

  assign dtr_o  = ctl_q[C_DTR]  & ~loop_on;
  assign rts_o  = ctl_q[C_RTS]  & ~loop_on;
  assign out1_o = ctl_q[C_OUT1] & ~loop_on;
  assign out2_o = ctl_q[C_OUT2] & ~loop_on;

  // R10: pins quiet in loopback
  a_r10_loop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[C_LOOP] |-> !(dtr_o || rts_o || out1_o || out2_o));
  // R9: in loopback, carrier status follows general out 2 one edge later
  a_r9_loop_dcd: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_rdata[C_LOOP]) && $past(ctl_rdata[C_OUT2]))
      |-> stat_rdata[4+L_DCD]);
  // R7: pending flag tracks the delta nibble
  a_r7_pend: assert property (@(posedge clk) disable iff (!rst_n)
    delta_pend == (stat_rdata[3:0] != 4'h0));
endmodule

// File: tb/test_modem_status_unit.sv
module test_modem_status_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_in = 1'b1, dsr_in = 1'b1, dcd_in = 1'b1, ri_in = 1'b0;
  logic ctl_wr = 1'b0, stat_rd = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata, stat_rdata;
  logic dtr_o, rts_o, out1_o, out2_o, delta_pend;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk; // 200 MHz

  modem_status_unit i_modem_status_unit (
    .clk(clk), .rst_n(rst_n), .cts_in(cts_in), .dsr_in(dsr_in),
    .dcd_in(dcd_in), .ri_in(ri_in), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .stat_rd(stat_rd), .ctl_rdata(ctl_rdata), .stat_rdata(stat_rdata),
    .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o),
    .delta_pend(delta_pend));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctl(logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    step(1);
    ctl_wr = 1'b0;
  endtask

  // read, check pre-clear value, then cleared value
  task automatic rd_stat(string req, logic [7:0] exp);
    stat_rd = 1'b1;
    chk(req, stat_rdata, exp);
    step(1);
    stat_rd = 1'b0;
    chk(req, stat_rdata, {exp[7:4], 4'h0});
    chk("R7", {7'h0, delta_pend}, 8'h00);
  endtask

  task automatic t_reset;
    chk("R1", stat_rdata, 8'hB0);
    chk("R1", ctl_rdata, 8'h08);
    chk("R1", {4'h0, dtr_o, rts_o, out1_o, out2_o}, 8'h01);
    chk("R1", {7'h0, delta_pend}, 8'h00);
  endtask

  task automatic t_cts;
    cts_in = 1'b0;
    step(2);
    chk("R2", stat_rdata, 8'hB0);
    step(1);
    chk("R3", stat_rdata, 8'hA1);
    chk("R7", {7'h0, delta_pend}, 8'h01);
    rd_stat("R5", 8'hA1);
    cts_in = 1'b1;
    step(3);
    rd_stat("R3", 8'hB1);
  endtask

  task automatic t_sticky;
    dsr_in = 1'b0;
    step(4);
    dsr_in = 1'b1;
    step(4);
    chk("R6", stat_rdata, 8'hB2);
    rd_stat("R6", 8'hB2);
  endtask

  task automatic t_ring;
    ri_in = 1'b1;
    step(3);
    chk("R4", stat_rdata, 8'hF0);
    chk("R4", {7'h0, delta_pend}, 8'h00);
    ri_in = 1'b0;
    step(3);
    rd_stat("R4", 8'hB4);
  endtask

  task automatic t_dcd;
    dcd_in = 1'b0;
    step(3);
    chk("R3", stat_rdata, 8'h38);
    cts_in = 1'b0;
    step(2);
    stat_rd = 1'b1;      // read in the edge that records the cts change
    step(1);
    stat_rd = 1'b0;
    chk("R5", stat_rdata, 8'h21);
    rd_stat("R5", 8'h21);
    dcd_in = 1'b1; cts_in = 1'b1;
    step(3);
    rd_stat("R3", 8'hB9);
  endtask

  task automatic t_ctl;
    wr_ctl(8'hE7);
    chk("R8", ctl_rdata, 8'h07);
    chk("R8", {4'h0, dtr_o, rts_o, out1_o, out2_o}, 8'h0E);
    step(1);
    chk("R8", stat_rdata, 8'hB0);
  endtask

  task automatic t_loop;
    wr_ctl(8'h11);
    chk("R10", {4'h0, dtr_o, rts_o, out1_o, out2_o}, 8'h00);
    chk("R8", ctl_rdata, 8'h11);
    step(1);
    rd_stat("R9", 8'h29);
    cts_in = 1'b0; ri_in = 1'b1;
    step(4);
    chk("R9", stat_rdata, 8'h20);
    wr_ctl(8'h1E);
    chk("R10", {4'h0, dtr_o, rts_o, out1_o, out2_o}, 8'h00);
    step(1);
    rd_stat("R9", 8'hDB);
    wr_ctl(8'h1A);
    step(1);
    rd_stat("R9", 8'h94);
  endtask

  task automatic t_exit;
    wr_ctl(8'h08);
    chk("R11", {4'h0, dtr_o, rts_o, out1_o, out2_o}, 8'h01);
    step(1);
    rd_stat("R11", 8'hE3);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_cts();
    t_sticky();
    t_ring();
    t_dcd();
    t_ctl();
    t_loop();
    t_exit();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule